// File: doc/BRIEF.md
# Frame Blanking Status and Vertical-Blank Interrupt

This block keeps the raster position of a video generator. A column counter advances on every pixel clock and a line counter advances at each column wrap. From that position it derives two status flags: a vertical-blank flag, which marks the interval between the end of one frame's visible area and the start of the next, and a line-fetch flag, which shows whether the fetch of the current line's data has finished. Both flags appear in an 8-bit status byte. At the moment vertical blanking begins, the block can also issue a non-maskable interrupt request to the processor.

The processor reads the status byte and marks each read with a one-cycle strobe. A read clears the vertical-blank flag before its natural end. The fetch flag does not respond to reads. During vertical blanking the fetch flag is held high. On visible lines it follows a configurable fetch-complete column. Pixel output and memory fetches are outside this block.

A three-state machine tracks the vertical phase. `ST_DISPLAY` covers the visible lines. `ST_BLANK_SET` is the blanking interval with the flag raised. `ST_BLANK_ACKED` is the blanking interval after a read has cleared the flag. The transitions are as follows. Start-of-blank moves `ST_DISPLAY` or `ST_BLANK_ACKED` to `ST_BLANK_SET`. A status read moves `ST_BLANK_SET` to `ST_BLANK_ACKED`. End-of-blank moves either blank state to `ST_DISPLAY`. Start-of-blank and end-of-blank take priority over a read.

Top module: `frame_status`

## Requirements
- R1: Reset sets the column and line counts to 0. After that, the column advances by one each clock. From COLS-1 it wraps to 0 and the line advances by one. From LINES-1 the line wraps to 0. The defaults are COLS=341 and LINES=262.
- R2: Status bit 7 (vertical-blank flag) becomes 1 in the first cycle in which the counts show line VBL_START (default 232), column 0.
- R3: Status bit 7 is 0 from the first cycle in which the counts show line VBL_END (default 8), column 0.
- R4: The flag may be 1 when stat_rd_i is high at a clock edge. In that case bit 7 is 0 after that edge, and it stays 0 until the next start of blanking.
- R5: stat_rd_i may be high at the same edge that brings the counts to line VBL_START, column 0. Bit 7 is still 1 after that edge.
- R6: nmi_o is high for exactly one cycle per frame. That cycle is the one in which bit 7 first becomes 1, and only if nmi_en_i was high at that edge. nmi_o is never high at any other time.
- R7: On visible lines (VBL_END <= line < VBL_START), status bit 6 (fetch flag) is 0 for column < FETCH_COL (default 256) and 1 for column >= FETCH_COL.
- R8: Status bit 6 is 1 on every cycle of the blanking lines (line >= VBL_START or line < VBL_END), whatever the state of bit 7. stat_rd_i never changes bit 6.
- R9: Status bits 5 to 0 are always 0. Right after reset the status byte is 8'h40, because line 0 lies in the blanking interval with the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_en_i | input | 1 | Control-register bit enabling the vertical-blank interrupt |
| stat_rd_i | input | 1 | One-cycle strobe marking a read of the status byte |
| status_o | output | 8 | Status byte: bit 7 vertical-blank flag, bit 6 fetch flag, bits 5..0 zero |
| nmi_o | output | 1 | One-cycle interrupt request at the start of vertical blanking |
| line_o | output | $clog2(LINES) | Current line count |
| col_o | output | $clog2(COLS) | Current column count |

## Verification
The hardest case to reach is a status read that lands on the very edge where blanking starts. In that case the flag must still rise and the interrupt must still fire. The bench reaches it by advancing until the counts show the last column of the line before VBL_START, then raising the read strobe for exactly that edge. To keep a frame short enough for several passes, the bench shrinks the raster to 16 columns by 12 lines, with blanking from line 9 to line 2 and fetch completing at column 10. It then compares every cycle of two whole frames against a count kept from reset.

// File: rtl/fstat_pkg.sv
package fstat_pkg;

    typedef enum logic [1:0] {
        ST_DISPLAY     = 2'd0,
        ST_BLANK_SET   = 2'd1,
        ST_BLANK_ACKED = 2'd2
    } vphase_e;

    localparam int STATUS_W  = 8;
    localparam int VFLAG_BIT = 7;
    localparam int HFLAG_BIT = 6;

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
    parameter int COLS      = 341,
    parameter int LINES     = 262,
    parameter int VBL_START = 232,
    parameter int VBL_END   = 8,
    localparam int COL_W    = $clog2(COLS),
    localparam int LINE_W   = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [COL_W-1:0]  col_o,
    output logic [LINE_W-1:0] line_o,
    output logic              ev_start_o,
    output logic              ev_end_o
);

    localparam logic [COL_W-1:0]  LAST_COL   = COL_W'(COLS - 1);
    localparam logic [LINE_W-1:0] LAST_LINE  = LINE_W'(LINES - 1);
    localparam int                START_PREV = (VBL_START == 0) ? LINES - 1 : VBL_START - 1;
    localparam int                END_PREV   = (VBL_END == 0) ? LINES - 1 : VBL_END - 1;
    localparam logic [LINE_W-1:0] START_PV   = LINE_W'(START_PREV);
    localparam logic [LINE_W-1:0] END_PV     = LINE_W'(END_PREV);

    logic [COL_W-1:0]  col_q;
    logic [LINE_W-1:0] line_q;
    logic              col_wrap;

    assign col_wrap = (col_q == LAST_COL);

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            line_q <= '0;
        end else if (col_wrap) begin
            col_q  <= '0;
            line_q <= (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
        end else begin
            col_q  <= col_q + 1'b1;
        end
    end

    // Events are true on the cycle whose following edge enters the target position.
    assign ev_start_o = col_wrap && (line_q == START_PV);
    assign ev_end_o   = col_wrap && (line_q == END_PV);
    assign col_o      = col_q;
    assign line_o     = line_q;

    p_col_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (col_q == LAST_COL) |=> (col_q == '0));
    p_col_step_r1: assert property (@(posedge clk) disable iff (rst)
        (col_q != LAST_COL) |=> (col_q == COL_W'($past(col_q) + 1'b1)));
    p_line_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (col_q != LAST_COL) |=> $stable(line_q));

endmodule

// File: rtl/blank_fsm.sv
module blank_fsm
    import fstat_pkg::*;
#(
    parameter int VBL_END = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ev_start_i,
    input  logic    ev_end_i,
    input  logic    rd_i,
    input  logic    nmi_en_i,
    output vphase_e phase_o,
    output logic    nmi_o
);

    // Line 0 lies inside the blanking interval whenever blanking ends after it.
    localparam vphase_e RST_PHASE = (VBL_END > 0) ? ST_BLANK_ACKED : ST_DISPLAY;

    vphase_e state_q, state_d;
    logic    nmi_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= RST_PHASE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISPLAY: begin
                if (ev_start_i) state_d = ST_BLANK_SET;
            end
            ST_BLANK_SET: begin
                if (ev_end_i)        state_d = ST_DISPLAY;
                else if (ev_start_i) state_d = ST_BLANK_SET;
                else if (rd_i)       state_d = ST_BLANK_ACKED;
            end
            ST_BLANK_ACKED: begin
                if (ev_end_i)        state_d = ST_DISPLAY;
                else if (ev_start_i) state_d = ST_BLANK_SET;
            end
            default: state_d = RST_PHASE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) nmi_q <= 1'b0;
        else     nmi_q <= ev_start_i && nmi_en_i;
    end

    assign phase_o = state_q;
    assign nmi_o   = nmi_q;

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_start_i && !ev_end_i) |=> (state_q == ST_BLANK_SET));
    p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BLANK_SET && rd_i && !ev_end_i && !ev_start_i) |=> (state_q == ST_BLANK_ACKED));
    p_end_clears_r3: assert property (@(posedge clk) disable iff (rst)
        ev_end_i |=> (state_q == ST_DISPLAY));
    p_nmi_gated_r6: assert property (@(posedge clk) disable iff (rst)
        nmi_q |-> ($past(nmi_en_i) && state_q == ST_BLANK_SET));
    p_nmi_single_r6: assert property (@(posedge clk) disable iff (rst)
        nmi_q |=> !nmi_q);

endmodule

// File: rtl/hfetch_flag.sv
module hfetch_flag
    import fstat_pkg::*;
#(
    parameter int COLS      = 341,
    parameter int FETCH_COL = 256,
    localparam int COL_W    = $clog2(COLS)
) (
    input  vphase_e          phase_i,
    input  logic [COL_W-1:0] col_i,
    output logic             hflag_o
);

    always_comb begin
        if (phase_i != ST_DISPLAY) hflag_o = 1'b1;
        else                       hflag_o = (int'(col_i) >= FETCH_COL);
    end

endmodule

// File: rtl/frame_status.sv
module frame_status
    import fstat_pkg::*;
#(
    parameter int COLS      = 341,
    parameter int LINES     = 262,
    parameter int FETCH_COL = 256,
    parameter int VBL_START = 232,
    parameter int VBL_END   = 8,
    localparam int COL_W    = $clog2(COLS),
    localparam int LINE_W   = $clog2(LINES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                nmi_en_i,
    input  logic                stat_rd_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                nmi_o,
    output logic [LINE_W-1:0]   line_o,
    output logic [COL_W-1:0]    col_o
);

    logic    ev_start, ev_end, hflag;
    vphase_e phase;

    raster_counter #(
        .COLS(COLS), .LINES(LINES), .VBL_START(VBL_START), .VBL_END(VBL_END)
    ) u_cnt (
        .clk(clk), .rst(rst), .col_o(col_o), .line_o(line_o),
        .ev_start_o(ev_start), .ev_end_o(ev_end)
    );

    blank_fsm #(.VBL_END(VBL_END)) u_fsm (
        .clk(clk), .rst(rst), .ev_start_i(ev_start), .ev_end_i(ev_end),
        .rd_i(stat_rd_i), .nmi_en_i(nmi_en_i), .phase_o(phase), .nmi_o(nmi_o)
    );

    hfetch_flag #(.COLS(COLS), .FETCH_COL(FETCH_COL)) u_hf (
        .phase_i(phase), .col_i(col_o), .hflag_o(hflag)
    );

    always_comb begin
        status_o            = '0;
        status_o[VFLAG_BIT] = (phase == ST_BLANK_SET);
        status_o[HFLAG_BIT] = hflag;
    end

    p_nmi_with_flag_r6: assert property (@(posedge clk) disable iff (rst)
        nmi_o |-> status_o[VFLAG_BIT]);
    p_hflag_in_blank_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[VFLAG_BIT]) |-> status_o[HFLAG_BIT]);
    p_vflag_at_start_r2: assert property (@(posedge clk) disable iff (rst)
        (line_o == LINE_W'(VBL_START) && col_o == '0) |-> status_o[VFLAG_BIT]);

endmodule

// File: tb/frame_status_tb.sv
`timescale 1ns/1ps
module frame_status_tb;

    localparam int COLS  = 16;
    localparam int LINES = 12;
    localparam int FETCH = 10;
    localparam int VS    = 9;
    localparam int VE    = 2;
    localparam int FRAME = COLS * LINES;
    localparam int CW    = $clog2(COLS);
    localparam int LW    = $clog2(LINES);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          nmi_en = 1'b0;
    logic          rd = 1'b0;
    logic [7:0]    status;
    logic          nmi;
    logic [LW-1:0] line;
    logic [CW-1:0] col;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    frame_status #(
        .COLS(COLS), .LINES(LINES), .FETCH_COL(FETCH), .VBL_START(VS), .VBL_END(VE)
    ) u_dut (
        .clk(clk), .rst(rst), .nmi_en_i(nmi_en), .stat_rd_i(rd),
        .status_o(status), .nmi_o(nmi), .line_o(line), .col_o(col)
    );

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic goto(int l, int c);
        for (int i = 0; i < 2 * FRAME; i++) begin
            @(negedge clk);
            if (int'(line) == l && int'(col) == c) return;
        end
        chk("goto position", int'(line) * 100 + int'(col), l * 100 + c);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset col", int'(col), 0);
        chk("R1 reset line", int'(line), 0);
        chk("R9 reset status", int'(status), 'h40);
        chk("R6 reset nmi", int'(nmi), 0);
    endtask

    // Two whole frames compared against the count kept from reset.
    task automatic t_walk();
        bit m = 1'b0;
        nmi_en = 1'b1;
        for (int i = 0; i < 2 * FRAME; i++) begin
            int ec, el, eh;
            @(negedge clk);
            ec = cyc % COLS;
            el = (cyc / COLS) % LINES;
            if (el == VS && ec == 0) m = 1'b1;
            if (el == VE && ec == 0) m = 1'b0;
            eh = (el >= VS || el < VE) ? 1 : (ec >= FETCH ? 1 : 0);
            chk("R1 col", int'(col), ec);
            chk("R1 line", int'(line), el);
            chk("R2/R3 vflag", int'(status[7]), int'(m));
            chk("R7/R8 hflag", int'(status[6]), eh);
            chk("R9 low bits", int'(status[5:0]), 0);
            chk("R6 nmi", int'(nmi), (el == VS && ec == 0) ? 1 : 0);
        end
    endtask

    task automatic t_nmi_off();
        int pulses = 0;
        nmi_en = 1'b0;
        goto(VE, 0);
        for (int i = 0; i < FRAME; i++) begin
            @(negedge clk);
            if (nmi) pulses++;
            if (int'(line) == VS && col == '0) chk("R2 vflag with nmi off", int'(status[7]), 1);
        end
        chk("R6 no nmi when disabled", pulses, 0);
        nmi_en = 1'b1;
    endtask

    task automatic t_read_clear();
        goto(VS, 3);
        chk("R2 vflag before read", int'(status[7]), 1);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        chk("R4 vflag after read", int'(status[7]), 0);
        chk("R8 hflag after read", int'(status[6]), 1);
        goto(VS + 1, 0);
        chk("R4 vflag stays clear", int'(status[7]), 0);
        chk("R8 hflag acked blank", int'(status[6]), 1);
        goto(VE, 0);
        chk("R3 vflag at end", int'(status[7]), 0);
        chk("R7 hflag col 0", int'(status[6]), 0);
    endtask

    task automatic t_collide();
        goto(VS - 1, COLS - 1);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        chk("R5 line", int'(line), VS);
        chk("R5 vflag despite read", int'(status[7]), 1);
        chk("R6 nmi on collide", int'(nmi), 1);
        @(negedge clk);
        chk("R6 nmi one cycle", int'(nmi), 0);
        chk("R5 vflag held", int'(status[7]), 1);
    endtask

    task automatic t_display_read();
        goto(4, 5);
        rd = 1'b1;
        @(negedge clk);
        chk("R8 hflag read before fetch", int'(status[6]), 0);
        chk("R4 vflag in display", int'(status[7]), 0);
        rd = 1'b0;
        goto(4, FETCH - 1);
        chk("R7 hflag last fetch col", int'(status[6]), 0);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        chk("R7 hflag fetch done", int'(status[6]), 1);
        chk("R8 hflag read after fetch", int'(status[6]), 1);
    endtask

    task automatic t_end_clear();
        goto(VE - 1, COLS - 1);
        chk("R2 vflag held to end", int'(status[7]), 1);
        @(negedge clk);
        chk("R3 vflag clear at end", int'(status[7]), 0);
        chk("R3 line", int'(line), VE);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_walk();
        t_nmi_off();
        t_read_clear();
        t_collide();
        t_display_read();
        t_end_clear();
        finish_run();
    end

endmodule